// File: doc/BRIEF.md
# Oscillator Trim Binary-Search Controller

This block finds the 8-bit trim code for an on-chip tunable oscillator without software stepping through codes. The code runs in the opposite sense to frequency: 00h gives the fastest oscillator and FFh the slowest. A measurement is one reference window, which is the interval between two pulses of an externally timed tick. During the window the block counts oscillator edges and compares the total with a target count. It fixes one code bit per window, starting from the most significant bit, so the full search takes eight windows.

A search starts on a start pulse while the block is idle. The first trial code is mid-scale (80h), and the trial code drives the oscillator directly during each window. Busy stays high for the whole search, and a one-cycle done pulse marks the end. Software can also load the code register directly, for example with a stored calibration value at power-up. A direct write takes priority over everything else and ends any search that is running.

Top module: `osc_trim_search`

## Requirements
- R1: After reset, trimCode is FFh, and busy and done are both 0.
- R2: If startReq is high while the block is idle and wrEn is low, the next cycle shows busy = 1 and trimCode = 80h. The first measurement window begins at the next windowTick.
- R3: For each bit from 7 down to 0, the bit is set and one window is measured. If the edge count is below targetCount, the bit is cleared again; otherwise it is kept. Because 00h is the fastest code, the final code is the largest code whose window count is not below targetCount. The result is 00h if no code reaches the target and FFh if every code does.
- R4: The edge counter is cleared at every windowTick that opens a window, and an oscEdge in that same cycle is not counted. The counter stops at 2^CNT_W-1 and does not wrap, so a fast oscillator reads as full scale.
- R5: A search uses exactly eight measurement windows after the arming tick. busy is high on all nine windowTick edges that the search uses.
- R6: done is a single-cycle pulse in the cycle after the final windowTick. In that cycle busy is already 0 and trimCode holds the result.
- R7: startReq while busy has no effect. trimCode and busy are unchanged in the next cycle, and the search finishes with the same result.
- R8: wrEn while idle loads wrData into trimCode, visible in the next cycle. It does not set busy or done.
- R9: wrEn during a search ends the search. In the next cycle busy is 0, trimCode equals wrData, and no done pulse follows.
- R10: While idle, with no startReq and no wrEn, trimCode holds its value across windowTick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a search; honoured only when idle |
| windowTick | input | 1 | One-cycle pulse marking each reference window boundary |
| oscEdge | input | 1 | One-cycle strobe per oscillator edge, synchronous to clk |
| targetCount | input | CNT_W | Edge count expected in one window at the wanted frequency |
| wrEn | input | 1 | Direct write of the trim code |
| wrData | input | 8 | Value for a direct write |
| trimCode | output | 8 | Trim code to the oscillator (00h fastest, FFh slowest) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search completes |

## Verification
The main search is run against a bench oscillator model whose edge count per window falls as the code rises. Seven pairs of model offset and target are used:
- Results inside the range show that a count equal to the target keeps the bit and a count one below clears it.
- A result of exactly 80h and a result of 7Fh test the mid-scale step in both directions.
- Targets that are out of reach in either direction test that the result clamps to 00h or FFh.
- A pair whose raw edge count exceeds the counter range separates a saturating counter from a wrapping one.

Directed runs cover a start request that arrives mid-search, a write that aborts a search, and a write while idle.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  localparam int TRIM_W = 8;
  localparam int BIT_W  = $clog2(TRIM_W);

  typedef struct packed {
    logic             loadMid;
    logic             clrCnt;
    logic             resolve;
    logic             lastBit;
    logic [BIT_W-1:0] bitSel;
  } trimStrobe_t;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_ARM  = 2'd1,
    SRCH_MEAS = 2'd2
  } srchState_t;

endpackage

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             edgeIn,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atMax;

  assign atMax = (count == CNT_MAX);

  // Clearing wins over counting, so an edge in the clearing cycle is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (edgeIn && !atMax) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/osc_trim_datapath.sv
module osc_trim_datapath
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trimStrobe_t       strobe,
  input  logic              oscEdge,
  input  logic [CNT_W-1:0]  targetCount,
  input  logic              wrEn,
  input  logic [TRIM_W-1:0] wrData,
  output logic [TRIM_W-1:0] trimCode
);

  localparam logic [TRIM_W-1:0] MID_CODE  = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] RST_CODE  = '1;

  logic [CNT_W-1:0]  edgeCount;
  logic              tooSlow;
  logic [TRIM_W-1:0] codeQ;
  logic [TRIM_W-1:0] trialNext;
  logic [BIT_W-1:0]  nextSel;

  osc_edge_counter #(
    .CNT_W (CNT_W)
  ) i_edgeCnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (strobe.clrCnt),
    .edgeIn (oscEdge),
    .count  (edgeCount)
  );

  // A larger code slows the oscillator, so a low count means the code is too large.
  assign tooSlow = (edgeCount < targetCount);
  assign nextSel = strobe.bitSel - 1'b1;

  always_comb begin
    trialNext = codeQ;
    if (strobe.resolve) begin
      if (tooSlow) begin
        trialNext[strobe.bitSel] = 1'b0;
      end
      if (!strobe.lastBit) begin
        trialNext[nextSel] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ <= RST_CODE;
    end else if (wrEn) begin
      codeQ <= wrData;
    end else if (strobe.loadMid) begin
      codeQ <= MID_CODE;
    end else begin
      codeQ <= trialNext;
    end
  end

  assign trimCode = codeQ;

endmodule

// File: rtl/osc_trim_control.sv
module osc_trim_control
  import osc_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        windowTick,
  input  logic        wrEn,
  output trimStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(TRIM_W - 1);

  srchState_t       state;
  logic [BIT_W-1:0] bitIdx;
  logic             isIdle;
  logic             inWindow;

  assign isIdle   = (state == SRCH_IDLE);
  assign inWindow = (state == SRCH_ARM) || (state == SRCH_MEAS);

  always_comb begin
    strobe.loadMid = isIdle && startReq && !wrEn;
    strobe.clrCnt  = inWindow && windowTick;
    strobe.resolve = (state == SRCH_MEAS) && windowTick && !wrEn;
    strobe.lastBit = (bitIdx == '0);
    strobe.bitSel  = bitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SRCH_IDLE;
      bitIdx <= TOP_BIT;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wrEn) begin
        state <= SRCH_IDLE;
      end else begin
        unique case (state)
          SRCH_IDLE: begin
            if (startReq) begin
              state  <= SRCH_ARM;
              bitIdx <= TOP_BIT;
            end
          end
          SRCH_ARM: begin
            if (windowTick) begin
              state <= SRCH_MEAS;
            end
          end
          SRCH_MEAS: begin
            if (windowTick) begin
              if (bitIdx == '0) begin
                state <= SRCH_IDLE;
                done  <= 1'b1;
              end else begin
                bitIdx <= bitIdx - 1'b1;
              end
            end
          end
          default: state <= SRCH_IDLE;
        endcase
      end
    end
  end

  assign busy = !isIdle;

endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic              windowTick,
  input  logic              oscEdge,
  input  logic [CNT_W-1:0]  targetCount,
  input  logic              wrEn,
  input  logic [TRIM_W-1:0] wrData,
  output logic [TRIM_W-1:0] trimCode,
  output logic              busy,
  output logic              done
);

  trimStrobe_t strobe;

  osc_trim_control i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .windowTick (windowTick),
    .wrEn       (wrEn),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  osc_trim_datapath #(
    .CNT_W (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .oscEdge     (oscEdge),
    .targetCount (targetCount),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .trimCode    (trimCode)
  );

endmodule

// File: rtl/osc_trim_search_chk.sv
module osc_trim_search_chk
  import osc_trim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              startReq,
  input logic              windowTick,
  input logic              wrEn,
  input logic [TRIM_W-1:0] wrData,
  input logic [TRIM_W-1:0] trimCode,
  input logic              busy,
  input logic              done
);

  localparam logic [TRIM_W-1:0] MID_CODE = {1'b1, {(TRIM_W-1){1'b0}}};

  AST_START_LOADS_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !busy && !wrEn) |=> (busy && trimCode == MID_CODE)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startReq && !wrEn && !windowTick) |=> (busy && $stable(trimCode))); // R7

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (trimCode == $past(wrData) && !busy && !done)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !startReq && !wrEn) |=> $stable(trimCode)); // R10

endmodule

bind osc_trim_search osc_trim_search_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startReq   (startReq),
  .windowTick (windowTick),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .trimCode   (trimCode),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_osc_trim_search.sv
`timescale 1ns/1ps
module test_osc_trim_search;

  localparam int CNT_W = 8;
  localparam int WIN   = 400;
  localparam int VEC_N = 7;
  // model offset, target, expected final code = clamp(offset - target, 0, 255)
  localparam int vecK   [VEC_N] = '{350, 300, 200, 177, 20, 600, 131};
  localparam int vecT   [VEC_N] = '{255, 100,  72,  50, 200, 10, 130};
  localparam int vecExp [VEC_N] = '{95,  200, 128, 127,   0, 255,  1};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startReq = 1'b0;
  logic             windowTick = 1'b0;
  logic             oscEdge = 1'b0;
  logic [CNT_W-1:0] targetCount = '0;
  logic             wrEn = 1'b0;
  logic [7:0]       wrData = '0;
  logic [7:0]       trimCode;
  logic             busy;
  logic             done;

  int checkCnt = 0;
  int errCnt   = 0;
  int kModel   = 0;
  int ph       = 0;
  int nCur     = 0;
  int busyTicks = 0;

  always #2.5 clk = ~clk;

  osc_trim_search #(.CNT_W(CNT_W)) i_osc_trim_search (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .windowTick(windowTick),
    .oscEdge(oscEdge), .targetCount(targetCount), .wrEn(wrEn), .wrData(wrData),
    .trimCode(trimCode), .busy(busy), .done(done)
  );

  // Oscillator model: edges per window fall as the code rises.
  always @(negedge clk) begin
    ph = (ph == WIN-1) ? 0 : ph + 1;
    if (ph == 0) begin
      nCur = kModel - int'(trimCode);
      if (nCur < 0) nCur = 0;
      if (nCur > WIN-1) nCur = WIN-1;
    end
    windowTick <= (ph == WIN-1);
    oscEdge    <= (ph < nCur);
  end

  always @(posedge clk) begin
    if (windowTick && busy) busyTicks <= busyTicks + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitDone(input string tag, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12*WIN; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    check({tag, " done seen"}, int'(seen), 1);
  endtask

  task automatic runVector(input int k, input int t, input int exp, input string tag);
    int tick0;
    bit seen;
    kModel = k;
    targetCount = CNT_W'(t);
    tick0 = busyTicks;
    pulseStart();
    check("R2 busy after start", int'(busy), 1);
    check("R2 trial code 80h", int'(trimCode), 8'h80);
    waitDone(tag, seen);
    if (seen) begin
      check({tag, " result"}, int'(trimCode), exp);
      check("R6 busy low with done", int'(busy), 0);
      check("R5 window ticks", busyTicks - tick0, 9);
      @(negedge clk);
      check("R6 done single cycle", int'(done), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog R5 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

  initial begin
    bit seen;
    logic [7:0] held;
    repeat (4) @(negedge clk);
    check("R1 reset code", int'(trimCode), 8'hFF);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(trimCode), 8'hFF);

    for (int v = 0; v < VEC_N; v++) begin
      runVector(vecK[v], vecT[v], vecExp[v], (v == 0 || v == 5) ? "R4 saturating R3" : "R3 search");
    end

    // R10: idle code holds across ticks
    held = trimCode;
    repeat (2*WIN) @(negedge clk);
    check("R10 idle hold", int'(trimCode), int'(held));

    // R8: direct write while idle
    @(negedge clk); wrEn = 1'b1; wrData = 8'h3C;
    @(negedge clk); wrEn = 1'b0;
    check("R8 idle write code", int'(trimCode), 8'h3C);
    check("R8 idle write busy", int'(busy), 0);

    // R7: start while busy ignored
    kModel = 300; targetCount = CNT_W'(100);
    pulseStart();
    while (ph != WIN/2) @(negedge clk);
    @(negedge clk);
    while (ph != WIN/2) @(negedge clk);
    held = trimCode;
    startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R7 code unchanged", int'(trimCode), int'(held));
    check("R7 still busy", int'(busy), 1);
    waitDone("R7", seen);
    check("R7 result unaffected", int'(trimCode), 200);

    // R9: write during search aborts it
    kModel = 200; targetCount = CNT_W'(72);
    pulseStart();
    repeat (3*WIN) @(negedge clk);
    wrEn = 1'b1; wrData = 8'hA5;
    @(negedge clk); wrEn = 1'b0;
    check("R9 busy cleared", int'(busy), 0);
    check("R9 code written", int'(trimCode), 8'hA5);
    seen = 1'b0;
    repeat (10*WIN) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check("R9 no done after abort", int'(seen), 0);
    check("R9 code kept", int'(trimCode), 8'hA5);

    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

endmodule